// File: doc/BRIEF.md
# Replicated-Register Steering Target Resolver

This block picks a group/instance pair that reaches a live (not fused-off, not power-gated) copy of a replicated register. A requester presents a register offset together with the fuse-derived availability masks. The block sorts the offset into one of seven steering classes, and each class carries its own rule for turning the masks into a pair. Every class owns a small set of inclusive address windows. Configuration logic loads these windows before lookups start, and it can also switch a window off.

The classes are searched in a fixed order, and the lowest-numbered class holding a matching window wins. If no class matches, a default pair supplied by the caller is returned. Offsets inside one fixed address window are first shifted by a caller-supplied base, with wrap-around, and only then compared. The lookup itself is combinational. The result is registered, so the answer for the inputs present at one rising edge is visible after that edge.

Top module: `steer_resolver`

## Requirements
- R1: An offset matches a window when it lies between the window's low and high bounds, inclusive at both ends. Low-1 and high+1 do not match that window.
- R2: When the offset hits windows in several classes, the result uses the lowest class number (0 to 6), whichever slot the window sits in.
- R3: With no hit, group_o and inst_o equal dflt_group_i and dflt_inst_i, hit_o is 0 and class_o is 0.
- R4: Class 0 (bank class) returns group 0. Its instance is the lowest set bit of a six-bit bank mask, in which fuse bit i of l3_fuse_i sets bits 2i and 2i+1. An empty mask gives instance 0.
- R5: Class 1 (memory-slice class) returns instance 0. Its group is the lowest present memory slice m, where slice m counts as present if msl_l3en_i[m] is set or any of ss_mask_i[4m+3:4m] is set. No present slice gives group 0.
- R6: Class 2 (node class) returns instance 0 and a group equal to twice the lowest present memory slice index, using the presence rule of R5.
- R7: Class 4 (sub-slice class) returns group = first_ss_i / 4 and instance = first_ss_i % 4.
- R8: Class 5 returns (0,0). Class 3 returns the fixed pair (1,0). Class 6 returns the fixed pair (0,1).
- R9: An offset in 0x380000..0x3BFFFF has bias_base_i added, modulo 2^24, before the comparison. Offsets outside that window are compared unchanged.
- R10: Reset drives all outputs to 0. Otherwise the outputs show the lookup of the inputs sampled at the previous rising edge.
- R11: A cfg_we_i pulse stores low, high and enable into slot cfg_slot_i of class cfg_cls_i at the edge. Lookups in that same cycle still use the old contents. A window stored with its enable at 0 never matches. Reset disables every window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Window write strobe |
| cfg_cls_i | input | 3 | Class of the written window |
| cfg_slot_i | input | 3 | Slot of the written window |
| cfg_lo_i | input | 24 | Low bound (inclusive) |
| cfg_hi_i | input | 24 | High bound (inclusive) |
| cfg_on_i | input | 1 | Window enable |
| dflt_group_i | input | 4 | Group returned on no hit |
| dflt_inst_i | input | 4 | Instance returned on no hit |
| bias_base_i | input | 24 | Base added to offsets in the biased window |
| offset_i | input | 24 | Register offset to classify |
| l3_fuse_i | input | 3 | Bank-pair enable fuses |
| msl_l3en_i | input | 4 | Per memory-slice cache enable fuses |
| ss_mask_i | input | 16 | Sub-slice enable mask, four per memory slice |
| first_ss_i | input | 4 | Index of the first enabled sub-slice |
| group_o | output | 4 | Resolved group |
| inst_o | output | 4 | Resolved instance |
| hit_o | output | 1 | A class window matched |
| class_o | output | 3 | Winning class, 0 on no hit |

## Verification
Two cases are hard to reach from the ports. One is an offset that lies in windows of several classes at once. The other is an offset that only lands in a window after the bias wraps past the top of the 24-bit space. The stimulus writes overlapping windows into different classes and slots, and also keeps a disabled window over a separate range. It then pairs offsets just inside the biased window with a base large enough to force the wrap. The mask-driven classes are swept across empty, single-bit and multi-bit fuse patterns, because the empty mask is the case where a lowest-set-bit search is most easily wrong.

// File: rtl/steer_pkg.sv
package steer_pkg;
  localparam int unsigned NUM_CLASSES = 7;
  localparam int unsigned CLS_W = $clog2(NUM_CLASSES);

  // order is priority: lower value wins
  typedef enum logic [CLS_W-1:0] {
    CL_BANK  = 3'd0,
    CL_MSL   = 3'd1,
    CL_NODE  = 3'd2,
    CL_FIXA  = 3'd3,
    CL_SUBSL = 3'd4,
    CL_ZERO  = 3'd5,
    CL_FIXB  = 3'd6
  } steer_cls_e;

  // index of lowest set bit, 0 for an empty vector
  function automatic logic [4:0] low_idx(input logic [31:0] v);
    logic [4:0] r;
    r = '0;
    for (int i = 31; i >= 0; i--)
      if (v[i]) r = 5'(i);
    return r;
  endfunction
endpackage

// File: rtl/steer_range_table.sv
module steer_range_table #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned NCLS   = 7,
  parameter int unsigned SLOTS  = 8,
  localparam int unsigned CW    = $clog2(NCLS),
  localparam int unsigned SW    = $clog2(SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CW-1:0]     wr_cls_i,
  input  logic [SW-1:0]     wr_slot_i,
  input  logic [ADDR_W-1:0] wr_lo_i,
  input  logic [ADDR_W-1:0] wr_hi_i,
  input  logic              wr_on_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NCLS-1:0]   hit_vec_o
);
  for (genvar c = 0; c < NCLS; c++) begin : g_cls
    logic [SLOTS-1:0] slot_hit;
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      logic [ADDR_W-1:0] lo_q, hi_q;
      logic              on_q;
      logic              sel;
      assign sel = wr_en_i && (wr_cls_i == CW'(c)) && (wr_slot_i == SW'(s));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          lo_q <= '0;
          hi_q <= '0;
          on_q <= 1'b0;
        end else if (sel) begin
          lo_q <= wr_lo_i;
          hi_q <= wr_hi_i;
          on_q <= wr_on_i;
        end
      end
      assign slot_hit[s] = on_q && (addr_i >= lo_q) && (addr_i <= hi_q);
    end
    assign hit_vec_o[c] = |slot_hit;
  end
endmodule

// File: rtl/steer_unit_masks.sv
module steer_unit_masks
  import steer_pkg::*;
#(
  parameter int unsigned ID_W       = 4,
  parameter int unsigned L3_FUSE_W  = 3,
  parameter int unsigned NUM_MSL    = 4,
  parameter int unsigned SS_PER_MSL = 4,
  localparam int unsigned NUM_SS    = NUM_MSL * SS_PER_MSL,
  localparam int unsigned BANK_W    = 2 * L3_FUSE_W
) (
  input  logic [L3_FUSE_W-1:0] l3_fuse_i,
  input  logic [NUM_MSL-1:0]   msl_l3en_i,
  input  logic [NUM_SS-1:0]    ss_mask_i,
  output logic [ID_W-1:0]      bank_idx_o,
  output logic [ID_W-1:0]      msl_idx_o
);
  logic [BANK_W-1:0]  bank_mask;
  logic [NUM_MSL-1:0] msl_present;

  // one fuse bit covers a pair of banks
  for (genvar i = 0; i < L3_FUSE_W; i++) begin : g_bank
    assign bank_mask[2*i +: 2] = {2{l3_fuse_i[i]}};
  end

  for (genvar m = 0; m < NUM_MSL; m++) begin : g_msl
    assign msl_present[m] = msl_l3en_i[m] | (|ss_mask_i[m*SS_PER_MSL +: SS_PER_MSL]);
  end

  assign bank_idx_o = ID_W'(low_idx(32'(bank_mask)));
  assign msl_idx_o  = ID_W'(low_idx(32'(msl_present)));
endmodule

// File: rtl/steer_resolver.sv
module steer_resolver
  import steer_pkg::*;
#(
  parameter int unsigned ADDR_W       = 24,
  parameter int unsigned SLOTS        = 8,
  parameter int unsigned ID_W         = 4,
  parameter int unsigned L3_FUSE_W    = 3,
  parameter int unsigned NUM_MSL      = 4,
  parameter int unsigned SS_PER_MSL   = 4,
  parameter int unsigned SS_PER_SLICE = 4,
  parameter logic [ADDR_W-1:0] BIAS_LO = 24'h380000,
  parameter logic [ADDR_W-1:0] BIAS_HI = 24'h3BFFFF,
  parameter int unsigned FIXA_GRP  = 1,
  parameter int unsigned FIXA_INST = 0,
  parameter int unsigned FIXB_GRP  = 0,
  parameter int unsigned FIXB_INST = 1,
  localparam int unsigned SW       = $clog2(SLOTS),
  localparam int unsigned NUM_SS   = NUM_MSL * SS_PER_MSL,
  localparam int unsigned SS_IDX_W = $clog2(NUM_SS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_we_i,
  input  logic [CLS_W-1:0]     cfg_cls_i,
  input  logic [SW-1:0]        cfg_slot_i,
  input  logic [ADDR_W-1:0]    cfg_lo_i,
  input  logic [ADDR_W-1:0]    cfg_hi_i,
  input  logic                 cfg_on_i,
  input  logic [ID_W-1:0]      dflt_group_i,
  input  logic [ID_W-1:0]      dflt_inst_i,
  input  logic [ADDR_W-1:0]    bias_base_i,
  input  logic [ADDR_W-1:0]    offset_i,
  input  logic [L3_FUSE_W-1:0] l3_fuse_i,
  input  logic [NUM_MSL-1:0]   msl_l3en_i,
  input  logic [NUM_SS-1:0]    ss_mask_i,
  input  logic [SS_IDX_W-1:0]  first_ss_i,
  output logic [ID_W-1:0]      group_o,
  output logic [ID_W-1:0]      inst_o,
  output logic                 hit_o,
  output logic [CLS_W-1:0]     class_o
);
  logic [ADDR_W-1:0]      eff_addr;
  logic [NUM_CLASSES-1:0] hit_vec;
  logic [ID_W-1:0]        bank_idx, msl_idx;
  logic                   any_hit;
  steer_cls_e             sel_cls;
  logic [ID_W-1:0]        nxt_grp, nxt_inst;

  // biased window wraps modulo 2^ADDR_W
  assign eff_addr = ((offset_i >= BIAS_LO) && (offset_i <= BIAS_HI))
                    ? offset_i + bias_base_i : offset_i;

  steer_range_table #(
    .ADDR_W (ADDR_W),
    .NCLS   (NUM_CLASSES),
    .SLOTS  (SLOTS)
  ) u_table (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (cfg_we_i),
    .wr_cls_i  (cfg_cls_i),
    .wr_slot_i (cfg_slot_i),
    .wr_lo_i   (cfg_lo_i),
    .wr_hi_i   (cfg_hi_i),
    .wr_on_i   (cfg_on_i),
    .addr_i    (eff_addr),
    .hit_vec_o (hit_vec)
  );

  steer_unit_masks #(
    .ID_W       (ID_W),
    .L3_FUSE_W  (L3_FUSE_W),
    .NUM_MSL    (NUM_MSL),
    .SS_PER_MSL (SS_PER_MSL)
  ) u_masks (
    .l3_fuse_i  (l3_fuse_i),
    .msl_l3en_i (msl_l3en_i),
    .ss_mask_i  (ss_mask_i),
    .bank_idx_o (bank_idx),
    .msl_idx_o  (msl_idx)
  );

  always_comb begin
    any_hit = 1'b0;
    sel_cls = CL_BANK;
    for (int c = NUM_CLASSES - 1; c >= 0; c--) begin
      if (hit_vec[c]) begin
        any_hit = 1'b1;
        sel_cls = steer_cls_e'(c);
      end
    end
  end

  always_comb begin
    nxt_grp  = '0;
    nxt_inst = '0;
    if (!any_hit) begin
      nxt_grp  = dflt_group_i;
      nxt_inst = dflt_inst_i;
    end else begin
      unique case (sel_cls)
        CL_BANK:  nxt_inst = bank_idx;
        CL_MSL:   nxt_grp  = msl_idx;
        CL_NODE:  nxt_grp  = ID_W'({msl_idx, 1'b0});
        CL_FIXA: begin
          nxt_grp  = ID_W'(FIXA_GRP);
          nxt_inst = ID_W'(FIXA_INST);
        end
        CL_SUBSL: begin
          nxt_grp  = ID_W'(32'(first_ss_i) / SS_PER_SLICE);
          nxt_inst = ID_W'(32'(first_ss_i) % SS_PER_SLICE);
        end
        CL_FIXB: begin
          nxt_grp  = ID_W'(FIXB_GRP);
          nxt_inst = ID_W'(FIXB_INST);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      group_o <= '0;
      inst_o  <= '0;
      hit_o   <= 1'b0;
      class_o <= '0;
    end else begin
      group_o <= nxt_grp;
      inst_o  <= nxt_inst;
      hit_o   <= any_hit;
      class_o <= any_hit ? CLS_W'(sel_cls) : '0;
    end
  end
endmodule

// File: rtl/steer_resolver_chk.sv
module steer_resolver_chk
  import steer_pkg::*;
#(
  parameter int unsigned ID_W         = 4,
  parameter int unsigned SS_PER_SLICE = 4,
  parameter int unsigned SS_IDX_W     = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [ID_W-1:0]     dflt_group_i,
  input logic [ID_W-1:0]     dflt_inst_i,
  input logic [SS_IDX_W-1:0] first_ss_i,
  input logic [ID_W-1:0]     group_o,
  input logic [ID_W-1:0]     inst_o,
  input logic                hit_o,
  input logic [CLS_W-1:0]    class_o
);
  logic primed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) primed <= 1'b0;
    else         primed <= 1'b1;
  end

  AST_MISS_DEFAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (primed && !hit_o) |-> (group_o == $past(dflt_group_i) && inst_o == $past(dflt_inst_i))); // R3

  AST_MISS_CLASS0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (class_o == '0)); // R3

  AST_CLASS_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(class_o) < NUM_CLASSES); // R2

  AST_BANK_GROUP0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && class_o == CLS_W'(CL_BANK)) |-> (group_o == '0)); // R4

  AST_MSL_INST0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && class_o == CLS_W'(CL_MSL)) |-> (inst_o == '0)); // R5

  AST_NODE_EVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && class_o == CLS_W'(CL_NODE)) |-> (group_o[0] == 1'b0 && inst_o == '0)); // R6

  AST_SUBSL_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (primed && hit_o && class_o == CLS_W'(CL_SUBSL)) |->
      ((32'(group_o) * SS_PER_SLICE + 32'(inst_o)) == 32'($past(first_ss_i)))); // R7

  AST_ZERO_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && class_o == CLS_W'(CL_ZERO)) |-> (group_o == '0 && inst_o == '0)); // R8
endmodule

bind steer_resolver steer_resolver_chk #(
  .ID_W         (ID_W),
  .SS_PER_SLICE (SS_PER_SLICE),
  .SS_IDX_W     (SS_IDX_W)
) u_chk (.*);

// File: tb/steer_resolver_tb.sv
`timescale 1ns/1ps
module steer_resolver_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_cls = '0;
  logic [2:0]  cfg_slot = '0;
  logic [23:0] cfg_lo = '0, cfg_hi = '0;
  logic        cfg_on = 1'b0;
  logic [3:0]  dflt_group = 4'h5, dflt_inst = 4'hA;
  logic [23:0] bias = 24'h010000;
  logic [23:0] offset = '0;
  logic [2:0]  fuse = 3'b110;
  logic [3:0]  l3en = 4'b0000;
  logic [15:0] ss_mask = 16'h0300;
  logic [3:0]  first_ss = 4'd6;
  logic [3:0]  group_o, inst_o;
  logic        hit_o;
  logic [2:0]  class_o;

  int n_checks = 0;
  int n_err = 0;

  bit [23:0] m_lo [7][8];
  bit [23:0] m_hi [7][8];
  bit        m_on [7][8];

  always #10 clk = ~clk;

  steer_resolver u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we), .cfg_cls_i(cfg_cls),
    .cfg_slot_i(cfg_slot), .cfg_lo_i(cfg_lo), .cfg_hi_i(cfg_hi), .cfg_on_i(cfg_on),
    .dflt_group_i(dflt_group), .dflt_inst_i(dflt_inst), .bias_base_i(bias),
    .offset_i(offset), .l3_fuse_i(fuse), .msl_l3en_i(l3en), .ss_mask_i(ss_mask),
    .first_ss_i(first_ss), .group_o(group_o), .inst_o(inst_o), .hit_o(hit_o),
    .class_o(class_o)
  );

  function automatic int first_one(input int v, input int n);
    for (int i = 0; i < n; i++) if (v[i]) return i;
    return 0;
  endfunction

  function automatic void ref_eval(output bit eh, output int ec, output int eg, output int ei);
    bit [23:0] a;
    int bank, pres;
    a = offset;
    if (offset >= 24'h380000 && offset <= 24'h3BFFFF) a = offset + bias;
    eh = 0; ec = 0;
    for (int c = 0; c < 7; c++)
      for (int s = 0; s < 8; s++)
        if (!eh && m_on[c][s] && a >= m_lo[c][s] && a <= m_hi[c][s]) begin
          eh = 1; ec = c;
        end
    bank = 0;
    for (int i = 0; i < 3; i++) if (fuse[i]) bank = bank | (3 << (2 * i));
    pres = 0;
    for (int m = 0; m < 4; m++)
      if (l3en[m] || ((ss_mask >> (4 * m)) & 16'hF) != 0) pres = pres | (1 << m);
    if (!eh) begin
      eg = dflt_group; ei = dflt_inst;
    end else begin
      case (ec)
        0: begin eg = 0; ei = first_one(bank, 6); end
        1: begin eg = first_one(pres, 4); ei = 0; end
        2: begin eg = 2 * first_one(pres, 4); ei = 0; end
        3: begin eg = 1; ei = 0; end
        4: begin eg = first_ss / 4; ei = first_ss % 4; end
        5: begin eg = 0; ei = 0; end
        default: begin eg = 0; ei = 1; end
      endcase
    end
  endfunction

  task automatic tick(input string tag);
    bit eh;
    int ec, eg, ei;
    ref_eval(eh, ec, eg, ei);
    if (cfg_we) begin
      m_lo[cfg_cls][cfg_slot] = cfg_lo;
      m_hi[cfg_cls][cfg_slot] = cfg_hi;
      m_on[cfg_cls][cfg_slot] = cfg_on;
    end
    @(negedge clk);
    n_checks++;
    if ({hit_o, class_o, group_o, inst_o} !== {eh, 3'(ec), 4'(eg), 4'(ei)}) begin
      n_err++;
      $display("FAIL %s off=%h: got hit=%0d cls=%0d grp=%0d ins=%0d, expected hit=%0d cls=%0d grp=%0d ins=%0d",
               tag, offset, hit_o, class_o, group_o, inst_o, eh, ec, eg, ei);
    end
  endtask

  task automatic wr(input int c, input int s, input bit [23:0] lo, input bit [23:0] hi,
                    input bit on, input string tag);
    cfg_we = 1'b1; cfg_cls = 3'(c); cfg_slot = 3'(s);
    cfg_lo = lo; cfg_hi = hi; cfg_on = on;
    tick(tag);
    cfg_we = 1'b0;
  endtask

  task automatic q(input bit [23:0] off, input string tag);
    offset = off;
    tick(tag);
  endtask

  task automatic clear_model();
    for (int c = 0; c < 7; c++)
      for (int s = 0; s < 8; s++) m_on[c][s] = 0;
  endtask

  task automatic reset_check(input string tag);
    n_checks++;
    if ({hit_o, class_o, group_o, inst_o} !== 12'h0) begin
      n_err++;
      $display("FAIL %s: got hit=%0d cls=%0d grp=%0d ins=%0d, expected all 0",
               tag, hit_o, class_o, group_o, inst_o);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_err++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    clear_model();
    offset = 24'h00B100;
    repeat (3) @(negedge clk);
    reset_check("R10 reset state");
    rst_ni = 1'b1;

    q(24'h00B100, "R3 miss with empty table");
    // R11 loading windows; the first lookup in the write cycle sees the old table
    wr(0, 0, 24'h00B100, 24'h00B3FF, 1, "R11 same-cycle lookup uses old table");
    wr(1, 0, 24'h00DD00, 24'h00DDFF, 1, "R11 write");
    wr(2, 2, 24'h00B000, 24'h00B0FF, 1, "R11 write");
    wr(3, 0, 24'h004000, 24'h0040FF, 1, "R11 write");
    wr(4, 7, 24'h005500, 24'h007FFF, 1, "R11 write");
    wr(5, 0, 24'h004000, 24'h004AFF, 1, "R11 write");
    wr(6, 0, 24'h00C800, 24'h00CFFF, 1, "R11 write");
    wr(1, 1, 24'h390010, 24'h390020, 1, "R11 write");
    wr(0, 3, 24'h001000, 24'h001FFF, 0, "R11 write disabled");
    wr(0, 1, 24'h00DD80, 24'h00DD8F, 1, "R11 write");
    wr(5, 1, 24'h3C0000, 24'h3C00FF, 1, "R11 write");

    q(24'h00B100, "R1 low bound");
    q(24'h00B3FF, "R1 high bound");
    q(24'h00B0FF, "R1 high bound node class");
    q(24'h00B400, "R1 high+1");
    q(24'h005500, "R1 low bound subslice");
    q(24'h0054FF, "R1 low-1");
    q(24'h007FFF, "R1 high bound subslice");
    q(24'h00DD85, "R2 bank over mslice");
    q(24'h004080, "R2 fixed-A over zero");
    q(24'h004100, "R2 zero class alone");
    q(24'h001800, "R11 disabled window");

    offset = 24'h00B200;
    foreach (fuse[i]) begin end
    fuse = 3'b000; tick("R4 empty fuse");
    fuse = 3'b001; tick("R4 fuse bit0");
    fuse = 3'b010; tick("R4 fuse bit1");
    fuse = 3'b100; tick("R4 fuse bit2");
    fuse = 3'b110; tick("R4 fuse bits 1,2");

    for (int k = 0; k < 2; k++) begin
      offset = (k == 0) ? 24'h00DD10 : 24'h00B050;
      l3en = 4'b0000; ss_mask = 16'h0000; tick(k == 0 ? "R5 none present" : "R6 none present");
      ss_mask = 16'h0300; tick(k == 0 ? "R5 subslice in slice 2" : "R6 subslice in slice 2");
      l3en = 4'b1000; ss_mask = 16'h0000; tick(k == 0 ? "R5 cache fuse slice 3" : "R6 cache fuse slice 3");
      ss_mask = 16'h0010; tick(k == 0 ? "R5 slice 1 beats 3" : "R6 slice 1 beats 3");
    end

    offset = 24'h006000;
    first_ss = 4'd0;  tick("R7 first 0");
    first_ss = 4'd5;  tick("R7 first 5");
    first_ss = 4'd15; tick("R7 first 15");

    q(24'h00C900, "R8 fixed-B");
    q(24'h004090, "R8 fixed-A");
    q(24'h004A00, "R8 zero pair");

    bias = 24'h010000;
    q(24'h380010, "R9 biased hit");
    q(24'h380021, "R9 biased high+1");
    q(24'h3C0010, "R9 outside window unbiased");
    q(24'h37FFFF, "R9 below window");
    bias = 24'hC83000;
    q(24'h388100, "R9 wrap to bank window");
    q(24'h3BFFFF, "R9 window top");

    dflt_group = 4'h3; dflt_inst = 4'hC;
    q(24'h000000, "R3 miss new default");

    for (int n = 0; n < 400; n++) begin
      bit [23:0] pool [12];
      pool = '{24'h00B0FF, 24'h00B100, 24'h00DD85, 24'h00DDFF, 24'h004000, 24'h004AFF,
               24'h004B00, 24'h006000, 24'h00C7FF, 24'h380010, 24'h388100, 24'h001000};
      offset = pool[$urandom_range(0, 11)];
      fuse = 3'($urandom); l3en = 4'($urandom); ss_mask = 16'($urandom) & 16'($urandom);
      first_ss = 4'($urandom);
      dflt_group = 4'($urandom); dflt_inst = 4'($urandom);
      bias = ($urandom_range(0, 1) == 1) ? 24'h010000 : 24'hC83000;
      tick("R2 mixed traffic");
    end

    @(negedge clk);
    rst_ni = 1'b0;
    clear_model();
    @(negedge clk);
    reset_check("R10 reset mid-run");
    rst_ni = 1'b1;
    bias = 24'h010000;
    q(24'h00B100, "R11 reset disables windows");
    q(24'h004000, "R11 reset disables windows");

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule